// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block keeps the settings of four digital potentiometers. Each potentiometer has one volatile 8-bit wiper register and four 8-bit storage registers. The storage registers model nonvolatile cells. A serial front end decodes bus traffic into single-cycle commands and hands them to the bank. The bank carries out direct reads and writes of wipers and storage bytes. It also moves bytes between a wiper and one of its storage registers, either for one potentiometer or for all four at once. Finally, it steps a wiper up or down by one tap.

A change to a storage register is treated as a slow write. The bank raises a busy flag for a parameterised number of clock cycles, and it ignores every command that arrives during that time. An active-low write-protect input blocks all changes to storage. When the bank leaves the recall reset, each wiper reloads from its own storage register 0. A separate power-on reset is the only thing that clears the storage bytes. For each potentiometer the bank drives a one-hot select of 256 lines, and the set line is the tap that the analog switch array should close.

Top module: `quad_pot_bank`

## Requirements
- R1: While `por_ni` is low, every storage byte clears to 00h. After both resets are released, `busy_o` and `rd_valid_o` are low and every wiper reads 00h.
- R2: On the first clock edge after the combined reset is released, each wiper loads its own storage register 0. Releasing `rst_ni` alone leaves the storage bytes unchanged.
- R3: Opcode 1 reads the wiper of the selected pot and opcode 2 writes `cmd_data_i` into it. A read result appears on `rd_data_o` with a one-cycle `rd_valid_o` pulse in the cycle after the command is accepted.
- R4: Opcode 3 reads the storage byte selected by `cmd_reg_i` and `cmd_pot_i`. Opcode 4 writes `cmd_data_i` into that byte.
- R5: Opcode 5 copies the selected storage byte into the selected wiper. Opcode 6 copies the selected wiper into the selected storage byte.
- R6: Opcode 7 copies storage register `cmd_reg_i` of every pot into that pot's wiper. Opcode 8 copies every wiper into storage register `cmd_reg_i` of its own pot. For both, `cmd_pot_i` is ignored.
- R7: Opcode 9 moves the selected wiper up by one and opcode 10 moves it down by one. An increment at FFh and a decrement at 00h leave the wiper unchanged.
- R8: An accepted storage-changing command (opcode 4, 6 or 8) raises `busy_o` in the next cycle and holds it for exactly `BUSY_CYCLES` cycles. Commands that change only wipers never raise `busy_o`.
- R9: While `busy_o` is high, every command is ignored. No wiper changes, no storage byte changes and no read pulse is produced.
- R10: While `wp_ni` is low, opcodes 4, 6 and 8 are dropped: storage is unchanged and `busy_o` stays low. Commands that change only wipers still work.
- R11: For each pot p, exactly one bit of `tap_o[p*256 +: 256]` is set, and its index equals the wiper value. Bit 0 is the low terminal and bit 255 is the high terminal.
- R12: Opcodes 0 and 11 to 15 change no register and produce no read pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous recall reset; storage is kept |
| por_ni | input | 1 | Active-low asynchronous power-on reset; clears storage |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 4 | Opcode |
| cmd_reg_i | input | 2 | Storage register index |
| cmd_pot_i | input | 2 | Potentiometer index |
| cmd_data_i | input | 8 | Write data |
| wp_ni | input | 1 | Active-low write protect for storage |
| busy_o | output | 1 | Storage write cycle in progress |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 8 | Read data |
| tap_o | output | 1024 | One-hot tap select, 256 lines per pot |

## Verification
The hardest condition to create is a command that lands inside the busy window. The window opens one cycle after a storage write is accepted and closes exactly `BUSY_CYCLES` later. The bench reaches it by issuing a storage write and then, on the very next cycles, a read and a wiper write. Later reads and tap checks show that neither command took effect. The recall path is also hard to observe, because only a reset reaches it. The bench loads distinct values into every storage register 0, moves the wipers elsewhere, and pulses only `rst_ni`. It then expects the wipers to return to the stored bytes while the storage bytes themselves survive.

// File: rtl/qpb_pkg.sv
package qpb_pkg;
  parameter int WIDTH     = 8;
  parameter int NUM_POTS  = 4;
  parameter int NUM_REGS  = 4;
  localparam int TAPS     = 1 << WIDTH;
  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int POT_AW   = $clog2(NUM_POTS);

  typedef enum logic [3:0] {
    OP_RD_WIP  = 4'd1,
    OP_WR_WIP  = 4'd2,
    OP_RD_ST   = 4'd3,
    OP_WR_ST   = 4'd4,
    OP_LOAD    = 4'd5,
    OP_SAVE    = 4'd6,
    OP_GLOAD   = 4'd7,
    OP_GSAVE   = 4'd8,
    OP_STEP_UP = 4'd9,
    OP_STEP_DN = 4'd10
  } cmd_op_e;

  typedef enum logic [2:0] {
    W_HOLD, W_DATA, W_STORE, W_UP, W_DN
  } wip_op_e;

  typedef struct packed {
    wip_op_e           wop;
    logic              st_we;
    logic              st_from_wip;
    logic [REG_AW-1:0] rsel;
  } pot_ctl_t;
endpackage

// File: rtl/qpb_cmd_dec.sv
module qpb_cmd_dec
  import qpb_pkg::*;
(
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [REG_AW-1:0] reg_i,
  input  logic [POT_AW-1:0] pot_i,
  input  logic              wp_ni,
  input  logic              busy_i,
  input  logic              recall_i,
  output pot_ctl_t          ctl_o [NUM_POTS],
  output logic              nv_start_o,
  output logic              rd_wip_o,
  output logic              rd_st_o
);
  cmd_op_e op;
  logic    acc, st_op, go;

  always_comb begin
    op    = cmd_op_e'(op_i);
    acc   = valid_i && !busy_i && !recall_i;
    st_op = (op == OP_WR_ST) || (op == OP_SAVE) || (op == OP_GSAVE);
    go    = acc && (!st_op || wp_ni);
    nv_start_o = go && st_op;
    rd_wip_o   = go && (op == OP_RD_WIP);
    rd_st_o    = go && (op == OP_RD_ST);
  end

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_ctl
    logic sel;
    assign sel = (pot_i == POT_AW'(p));
    always_comb begin
      ctl_o[p].wop         = W_HOLD;
      ctl_o[p].st_we       = 1'b0;
      ctl_o[p].st_from_wip = 1'b0;
      ctl_o[p].rsel        = reg_i;
      if (go) begin
        unique case (op)
          OP_WR_WIP:  if (sel) ctl_o[p].wop = W_DATA;
          OP_WR_ST:   if (sel) ctl_o[p].st_we = 1'b1;
          OP_LOAD:    if (sel) ctl_o[p].wop = W_STORE;
          OP_SAVE:    if (sel) begin
                        ctl_o[p].st_we       = 1'b1;
                        ctl_o[p].st_from_wip = 1'b1;
                      end
          OP_GLOAD:   ctl_o[p].wop = W_STORE;
          OP_GSAVE:   begin
                        ctl_o[p].st_we       = 1'b1;
                        ctl_o[p].st_from_wip = 1'b1;
                      end
          OP_STEP_UP: if (sel) ctl_o[p].wop = W_UP;
          OP_STEP_DN: if (sel) ctl_o[p].wop = W_DN;
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qpb_nv_timer.sv
module qpb_nv_timer #(
  parameter int BUSY_CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/qpb_pot_slice.sv
module qpb_pot_slice
  import qpb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             recall_i,
  input  pot_ctl_t         ctl_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] wip_o,
  output logic [WIDTH-1:0] st_sel_o,
  output logic [TAPS-1:0]  tap_o
);
  logic [WIDTH-1:0] st_q [NUM_REGS];
  logic [WIDTH-1:0] wip_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      for (int r = 0; r < NUM_REGS; r++) st_q[r] <= '0;
    end else if (ctl_i.st_we) begin
      st_q[ctl_i.rsel] <= ctl_i.st_from_wip ? wip_q : data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wip_q <= '0;
    else if (recall_i) wip_q <= st_q[0];
    else begin
      unique case (ctl_i.wop)
        W_DATA:  wip_q <= data_i;
        W_STORE: wip_q <= st_q[ctl_i.rsel];
        W_UP:    if (wip_q != '1) wip_q <= wip_q + 1'b1;
        W_DN:    if (wip_q != '0) wip_q <= wip_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign wip_o    = wip_q;
  assign st_sel_o = st_q[ctl_i.rsel];

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap_o[t] = (wip_q == WIDTH'(t));
  end
endmodule

// File: rtl/quad_pot_bank.sv
module quad_pot_bank
  import qpb_pkg::*;
#(
  parameter int BUSY_CYCLES = 500
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     por_ni,
  input  logic                     cmd_valid_i,
  input  logic [3:0]               cmd_op_i,
  input  logic [REG_AW-1:0]        cmd_reg_i,
  input  logic [POT_AW-1:0]        cmd_pot_i,
  input  logic [WIDTH-1:0]         cmd_data_i,
  input  logic                     wp_ni,
  output logic                     busy_o,
  output logic                     rd_valid_o,
  output logic [WIDTH-1:0]         rd_data_o,
  output logic [NUM_POTS*TAPS-1:0] tap_o
);
  logic             rst_all_n;
  logic             recall_q;
  logic             nv_start, rd_wip, rd_st;
  pot_ctl_t         ctl [NUM_POTS];
  logic [WIDTH-1:0] wip_w [NUM_POTS];
  logic [WIDTH-1:0] st_w  [NUM_POTS];

  assign rst_all_n = rst_ni & por_ni;

  // one recall cycle after any reset release
  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) recall_q <= 1'b1;
    else            recall_q <= 1'b0;
  end

  qpb_cmd_dec u_dec (
    .valid_i    (cmd_valid_i),
    .op_i       (cmd_op_i),
    .reg_i      (cmd_reg_i),
    .pot_i      (cmd_pot_i),
    .wp_ni      (wp_ni),
    .busy_i     (busy_o),
    .recall_i   (recall_q),
    .ctl_o      (ctl),
    .nv_start_o (nv_start),
    .rd_wip_o   (rd_wip),
    .rd_st_o    (rd_st)
  );

  qpb_nv_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_all_n),
    .start_i (nv_start),
    .busy_o  (busy_o)
  );

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
    qpb_pot_slice u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_all_n),
      .por_ni   (por_ni),
      .recall_i (recall_q),
      .ctl_i    (ctl[p]),
      .data_i   (cmd_data_i),
      .wip_o    (wip_w[p]),
      .st_sel_o (st_w[p]),
      .tap_o    (tap_o[p*TAPS +: TAPS])
    );
  end

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_wip || rd_st;
      if (rd_wip)     rd_data_o <= wip_w[cmd_pot_i];
      else if (rd_st) rd_data_o <= st_w[cmd_pot_i];
    end
  end
endmodule

// File: rtl/qpb_chk.sv
module qpb_chk
  import qpb_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     por_ni,
  input logic                     cmd_valid_i,
  input logic [3:0]               cmd_op_i,
  input logic                     wp_ni,
  input logic                     busy_o,
  input logic                     rd_valid_o,
  input logic [NUM_POTS*TAPS-1:0] tap_o
);
  logic off;
  assign off = !rst_ni || !por_ni;

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_a
    AST_TAP_ONEHOT: assert property (@(posedge clk_i) disable iff (off)
      $countones(tap_o[p*TAPS +: TAPS]) == 1); // R11
  end

  AST_RD_HAS_CMD: assert property (@(posedge clk_i) disable iff (off)
    rd_valid_o |-> $past(cmd_valid_i && !busy_o &&
                         (cmd_op_i == 4'd1 || cmd_op_i == 4'd3))); // R3

  AST_BUSY_FROM_STORE_CMD: assert property (@(posedge clk_i) disable iff (off)
    $rose(busy_o) |-> $past(cmd_valid_i &&
                            (cmd_op_i == 4'd4 || cmd_op_i == 4'd6 || cmd_op_i == 4'd8))); // R8

  AST_BUSY_NEEDS_WP: assert property (@(posedge clk_i) disable iff (off)
    $rose(busy_o) |-> $past(wp_ni)); // R10

  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (off)
    (cmd_valid_i && busy_o) |=> ($stable(tap_o) && !rd_valid_o)); // R9
endmodule

bind quad_pot_bank qpb_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_ni      (por_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .wp_ni       (wp_ni),
  .busy_o      (busy_o),
  .rd_valid_o  (rd_valid_o),
  .tap_o       (tap_o)
);

// File: tb/tb_quad_pot_bank.sv
module tb_quad_pot_bank;
  localparam int BUSY = 40;

  logic        clk = 1'b0;
  logic        rst_n, por_n, cmd_valid, wp_n;
  logic [3:0]  cmd_op;
  logic [1:0]  cmd_reg, cmd_pot;
  logic [7:0]  cmd_data;
  logic        busy, rd_valid;
  logic [7:0]  rd_data;
  logic [1023:0] tap;

  int total = 0, bad = 0;
  logic [7:0] m_wip [4];
  logic [7:0] m_st  [4][4];
  logic [7:0] exp_d [$];
  string      exp_r [$];

  always #5 clk = ~clk;

  quad_pot_bank #(.BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .cmd_valid_i(cmd_valid),
    .cmd_op_i(cmd_op), .cmd_reg_i(cmd_reg), .cmd_pot_i(cmd_pot),
    .cmd_data_i(cmd_data), .wp_ni(wp_n), .busy_o(busy),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .tap_o(tap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_valid === 1'b1) begin
      if (exp_d.size() == 0) chk("R9 unexpected read", 32'd1, 32'd0);
      else chk(exp_r.pop_front(), {24'd0, rd_data}, {24'd0, exp_d.pop_front()});
    end
  end

  task automatic issue(input logic [3:0] op, input logic [1:0] r, input logic [1:0] p,
                       input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_reg = r; cmd_pot = p; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd_wip(input int p, input string req);
    exp_d.push_back(m_wip[p]); exp_r.push_back(req);
    issue(4'd1, 2'd0, 2'(p), 8'h00);
  endtask

  task automatic rd_st(input int p, input int r, input string req);
    exp_d.push_back(m_st[p][r]); exp_r.push_back(req);
    issue(4'd3, 2'(r), 2'(p), 8'h00);
  endtask

  task automatic wr_wip(input int p, input logic [7:0] d);
    issue(4'd2, 2'd0, 2'(p), d);
    m_wip[p] = d;
  endtask

  task automatic wr_st(input int p, input int r, input logic [7:0] d);
    issue(4'd4, 2'(r), 2'(p), d);
    if (wp_n) m_st[p][r] = d;
    wait_idle();
  endtask

  task automatic chk_tap(input int p, input string req);
    chk(req, {31'd0, tap[p*256 +: 256] == (256'd1 << m_wip[p])}, 32'd1);
  endtask

  task automatic do_reset(input logic por);
    @(negedge clk);
    rst_n = 1'b0; if (por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    if (por) for (int p = 0; p < 4; p++) for (int r = 0; r < 4; r++) m_st[p][r] = 8'h00;
    for (int p = 0; p < 4; p++) m_wip[p] = m_st[p][0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    cmd_valid = 0; cmd_op = 0; cmd_reg = 0; cmd_pot = 0; cmd_data = 0;
    wp_n = 1; rst_n = 1; por_n = 1;
    do_reset(1'b1);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    for (int p = 0; p < 4; p++) begin rd_wip(p, "R1 wiper"); chk_tap(p, "R11 tap at 00"); end

    // R3 direct wiper access
    for (int p = 0; p < 4; p++) wr_wip(p, 8'(8'h10 * (p + 1) + 3));
    chk("R8 no busy on wiper write", {31'd0, busy}, 32'd0);
    for (int p = 0; p < 4; p++) begin rd_wip(p, "R3 wiper rd"); chk_tap(p, "R11 tap"); end

    // R8 busy length, R9 ignore while busy
    issue(4'd4, 2'd2, 2'd1, 8'hA5);
    m_st[1][2] = 8'hA5;
    chk("R8 busy start", {31'd0, busy}, 32'd1);
    issue(4'd1, 2'd0, 2'd0, 8'h00);
    chk("R9 read ignored", {31'd0, rd_valid}, 32'd0);
    issue(4'd2, 2'd0, 2'd0, 8'h77);
    chk_tap(0, "R9 wiper write ignored");
    issue(4'd4, 2'd0, 2'd3, 8'h5A);
    n = 3;
    while (busy) begin n++; @(negedge clk); end
    chk("R8 busy length", n, BUSY);
    rd_wip(0, "R9 wiper kept");
    rd_st(3, 0, "R9 store write ignored");
    rd_st(1, 2, "R4 store rd");

    // store reg0 values
    for (int p = 0; p < 4; p++) wr_st(p, 0, 8'(8'h11 * (p + 1)));
    for (int p = 0; p < 4; p++) rd_st(p, 0, "R4 store reg0");

    // R5 single transfers
    issue(4'd6, 2'd1, 2'd3, 8'h00); m_st[3][1] = m_wip[3];
    chk("R8 busy on save", {31'd0, busy}, 32'd1);
    wait_idle();
    rd_st(3, 1, "R5 save");
    issue(4'd5, 2'd2, 2'd1, 8'h00); m_wip[1] = m_st[1][2];
    chk("R8 no busy on load", {31'd0, busy}, 32'd0);
    rd_wip(1, "R5 load");
    chk_tap(1, "R11 tap after load");

    // R6 global transfers
    issue(4'd8, 2'd3, 2'd2, 8'h00);
    for (int p = 0; p < 4; p++) m_st[p][3] = m_wip[p];
    wait_idle();
    for (int p = 0; p < 4; p++) rd_st(p, 3, "R6 global save");
    for (int p = 0; p < 4; p++) wr_wip(p, 8'hC0);
    issue(4'd7, 2'd3, 2'd2, 8'h00);
    for (int p = 0; p < 4; p++) m_wip[p] = m_st[p][3];
    for (int p = 0; p < 4; p++) rd_wip(p, "R6 global load");

    // R7 step with saturation
    wr_wip(2, 8'hFE);
    issue(4'd9, 0, 2'd2, 0); m_wip[2] = 8'hFF;
    chk_tap(2, "R11 tap at FF");
    issue(4'd9, 0, 2'd2, 0);
    rd_wip(2, "R7 inc saturate");
    issue(4'd10, 0, 2'd2, 0); m_wip[2] = 8'hFE;
    rd_wip(2, "R7 dec");
    wr_wip(0, 8'h01);
    issue(4'd10, 0, 2'd0, 0); m_wip[0] = 8'h00;
    issue(4'd10, 0, 2'd0, 0);
    rd_wip(0, "R7 dec saturate");
    chk_tap(0, "R11 tap at 00 after dec");

    // R10 write protect
    wp_n = 1'b0;
    issue(4'd4, 2'd0, 2'd0, 8'h99);
    chk("R10 no busy", {31'd0, busy}, 32'd0);
    issue(4'd8, 2'd0, 2'd0, 8'h00);
    chk("R10 no busy gsave", {31'd0, busy}, 32'd0);
    rd_st(0, 0, "R10 store kept");
    rd_st(2, 0, "R10 gsave dropped");
    wr_wip(3, 8'h42);
    rd_wip(3, "R10 wiper write ok");
    wp_n = 1'b1;

    // R12 unused opcodes
    issue(4'd0, 2'd0, 2'd0, 8'hEE);
    chk("R12 no read", {31'd0, rd_valid}, 32'd0);
    issue(4'd11, 2'd1, 2'd1, 8'hEE);
    issue(4'd15, 2'd0, 2'd2, 8'hEE);
    chk("R12 no busy", {31'd0, busy}, 32'd0);
    for (int p = 0; p < 4; p++) rd_wip(p, "R12 wiper kept");
    rd_st(1, 1, "R12 store kept");

    // R2 recall reset keeps storage
    do_reset(1'b0);
    for (int p = 0; p < 4; p++) begin rd_wip(p, "R2 recall"); chk_tap(p, "R2 tap"); end
    rd_st(1, 2, "R2 store kept");

    // R1 power-on reset clears storage
    do_reset(1'b1);
    rd_st(1, 2, "R1 store cleared");
    rd_wip(2, "R1 wiper zero");
    @(negedge clk);
    chk("R3 scoreboard drained", exp_d.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule